// File: doc/BRIEF.md
# Flash Data Array Write Controller

This block manages a small nonvolatile data array of 64 cells, each 12 bits wide, of which software sees only the low byte. A processor reaches it through three things: an address register, a data register, and a control register that it may only change one bit at a time. With these it can read a single cell into the data register, erase an 8-cell row, or fill four write latches and have them programmed into the array as a group. Because the cells are slow to change, the block holds the processor in a stall for the full length of every erase or program cycle. Each clock counts as one instruction cycle.

Two guards protect the array from stray writes. Erase-select must be followed in the very next cycle by write-enable. Write-enable must be followed in the very next cycle by the write strobe. If the next step does not come in time, the arming bit clears itself. The fourth latch load, at an address whose two top bits are 00 and whose two low bits are 11, starts the program cycle by itself. The array is a behavioural register model that stands in for real cells. Programming can only turn ones into zeros, and erasing turns a whole row back to ones.

Top module: `nvDataCtrl`

## Requirements
- R1: After reset, stall is 0, ctrlQ is 0, dataQ is 0, and every cell reads back as 0xFF.
- R2: A control bit-set with ctrlBit=0 (read) copies the low byte of cell address[5:0] into dataQ at that clock edge. dataQ then keeps its value until the next read or the next write with regSel=1 (data register). A write with regSel=0 loads the address register.
- R3: An armed write strobe (ctrlBit=1) while erase-select (ctrlBit=3) is set erases the row selected by address[5:3]. All 8 cells of that row read back as 0xFF, the other rows are unchanged, and the stall lasts ERASE_CYC cycles.
- R4: An armed write strobe without erase-select copies dataQ into the latch selected by address[1:0]. When the address is not final, there is no stall.
- R5: An armed write strobe at a final address (address[7:6]=00, address[1:0]=11) loads the last latch. It then programs latch i into cell {address[5:2], i} for i = 0..3, stalls for WRITE_CYC cycles, and afterwards returns all latches to 0xFF.
- R6: If write-enable (ctrlBit=2) is not set in the cycle right after erase-select is set, erase-select reads 0 again in ctrlQ[3]. A later enable and write strobe then erase nothing.
- R7: If the write strobe is not set in the cycle right after write-enable is set, write-enable clears (ctrlQ[2]=0). A later write strobe then changes nothing.
- R8: A write strobe while write-enable is not armed is ignored: there is no stall and the array is unchanged.
- R9: While an erase or program cycle runs, stall=1 and ctrlQ[1]=1. When it ends, ctrlQ returns to 0.
- R10: Register writes and control bit-sets that arrive while stall=1 are ignored.
- R11: Programming without a prior erase stores the bitwise AND of the old cell contents and the latch value.
- R12: An armed write strobe with address[1:0]=11 but address[7:6] not 00 only loads a latch. It does not program and does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlSet | input | 1 | Bit-set operation on the control register |
| ctrlBit | input | 3 | Bit to set: 0 read, 1 write strobe, 2 write-enable, 3 erase-select |
| regWr | input | 1 | Write to the address or data register |
| regSel | input | 1 | 0 selects the address register, 1 selects the data register |
| regWdata | input | 8 | Value for the register write |
| stall | output | 1 | Holds the processor during an erase or program cycle |
| ctrlQ | output | 4 | Control readback {erase-select, write-enable, write busy, 0} |
| dataQ | output | 8 | Data register |

## Verification
A sweep reads all 64 cells after reset. A second sweep runs after every group has been programmed with a position-dependent pattern, which shows that each latch lands in the cell matching its own index. A second pattern is then programmed over one group without an erase, which separates AND behaviour from plain overwrite. A single-row erase follows a full sweep, which shows that exactly eight cells changed. Broken unlock sequences, a late strobe, an unarmed strobe, an off-range final address and traffic during a stall are each followed by readback of the cells they could have touched.

// File: rtl/nvd_pkg.sv
package nvd_pkg;
  localparam logic [2:0] BIT_READ  = 3'd0;
  localparam logic [2:0] BIT_GO    = 3'd1;
  localparam logic [2:0] BIT_ARM   = 3'd2;
  localparam logic [2:0] BIT_ERASE = 3'd3;

  typedef struct packed {
    logic rdStb;
    logic latchStb;
    logic progStb;
    logic eraseStb;
  } nvdStrobes_t;
endpackage

// File: rtl/nvdCtrl.sv
module nvdCtrl
  import nvd_pkg::*;
#(
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlSet,
  input  logic [2:0]  ctrlBit,
  input  logic        finalAddr,
  output nvdStrobes_t stb,
  output logic        busy,
  output logic        wrenQ,
  output logic        freeQ
);
  localparam int MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CW-1:0] cnt;
  logic opErase, freeArm, wrenArm;
  logic setRd, setGo, setArm, setErase, goOk, startErase, startProg, done;

  assign setRd      = ctrlSet && !busy && (ctrlBit == BIT_READ);
  assign setGo      = ctrlSet && !busy && (ctrlBit == BIT_GO);
  assign setArm     = ctrlSet && !busy && (ctrlBit == BIT_ARM);
  assign setErase   = ctrlSet && !busy && (ctrlBit == BIT_ERASE);
  assign goOk       = setGo && wrenQ && wrenArm;
  assign startErase = goOk && freeQ;
  assign startProg  = goOk && !freeQ && finalAddr;
  assign done       = busy && (cnt == '0);

  assign stb.rdStb    = setRd;
  assign stb.latchStb = goOk && !freeQ;
  assign stb.progStb  = done && !opErase;
  assign stb.eraseStb = done && opErase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      opErase <= 1'b0;
      wrenQ   <= 1'b0;
      freeQ   <= 1'b0;
      freeArm <= 1'b0;
      wrenArm <= 1'b0;
    end else begin
      freeArm <= setErase;
      wrenArm <= setArm;
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == '0) begin
          busy  <= 1'b0;
          wrenQ <= 1'b0;
          freeQ <= 1'b0;
        end
      end else begin
        if (setErase)
          freeQ <= 1'b1;
        else if ((freeArm && !setArm) || (wrenArm && !goOk))
          freeQ <= 1'b0;
        if (setArm)
          wrenQ <= 1'b1;
        else if (wrenArm)
          wrenQ <= startErase || startProg;
        if (startErase || startProg) begin
          busy    <= 1'b1;
          opErase <= startErase;
          cnt     <= startErase ? CW'(ERASE_CYC - 1) : CW'(WRITE_CYC - 1);
        end
      end
    end
  end

  // R6
  free_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeArm && !busy && !(ctrlSet && ctrlBit == BIT_ARM)) |=> !freeQ);
  // R7
  wren_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrenArm && !busy && !(ctrlSet && ctrlBit == BIT_GO)) |=> !wrenQ);
  // R8
  unarmed_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlSet && ctrlBit == BIT_GO && !wrenQ) |=> !busy);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctrlSet && ctrlBit == BIT_GO && wrenQ));
  // R10
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!stb.rdStb && !stb.latchStb));
endmodule

// File: rtl/nvdPath.sv
module nvdPath
  import nvd_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ROW_LEN = 8,
  parameter int LATCHES = 4,
  parameter int DATA_W  = 8,
  parameter int CELL_W  = 12,
  parameter int REG_AW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busy,
  input  nvdStrobes_t       stb,
  output logic              finalAddr,
  output logic [DATA_W-1:0] dataQ
);
  localparam int AW       = $clog2(DEPTH);
  localparam int ROW_AW   = $clog2(ROW_LEN);
  localparam int LATCH_AW = $clog2(LATCHES);

  logic [REG_AW-1:0] addrQ;
  logic [DATA_W-1:0] latchQ [LATCHES];
  logic [CELL_W-1:0] mem [DEPTH];
  logic [AW-1:0]     cellIdx, eraseBase, progBase;
  logic              latchesIdle;

  assign cellIdx   = addrQ[AW-1:0];
  assign eraseBase = {addrQ[AW-1:ROW_AW], {ROW_AW{1'b0}}};
  assign progBase  = {addrQ[AW-1:LATCH_AW], {LATCH_AW{1'b0}}};
  assign finalAddr = (addrQ[REG_AW-1:AW] == '0) && (&addrQ[LATCH_AW-1:0]);

  always_comb begin
    latchesIdle = 1'b1;
    for (int i = 0; i < LATCHES; i++)
      if (latchQ[i] != '1) latchesIdle = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      for (int i = 0; i < LATCHES; i++) latchQ[i] <= '1;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
    end else begin
      if (stb.rdStb) dataQ <= mem[cellIdx][DATA_W-1:0];
      if (regWr && !busy) begin
        if (regSel) dataQ <= regWdata;
        else        addrQ <= REG_AW'(regWdata);
      end
      if (stb.latchStb) latchQ[addrQ[LATCH_AW-1:0]] <= dataQ;
      if (stb.progStb) begin
        for (int i = 0; i < LATCHES; i++) begin
          mem[progBase + AW'(i)] <= mem[progBase + AW'(i)] &
                                    {{(CELL_W-DATA_W){1'b1}}, latchQ[i]};
          latchQ[i] <= '1;
        end
      end
      if (stb.eraseStb)
        for (int j = 0; j < ROW_LEN; j++) mem[eraseBase + AW'(j)] <= '1;
    end
  end

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdStb && !(regWr && regSel && !busy)) |=> $stable(dataQ));
  // R5
  latch_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.progStb |=> latchesIdle);
  // R3
  erase_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseStb |=> (mem[eraseBase] == '1));
endmodule

// File: rtl/nvDataCtrl.sv
module nvDataCtrl
  import nvd_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ROW_LEN   = 8,
  parameter int LATCHES   = 4,
  parameter int DATA_W    = 8,
  parameter int CELL_W    = 12,
  parameter int REG_AW    = 8,
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlSet,
  input  logic [2:0]        ctrlBit,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic              stall,
  output logic [3:0]        ctrlQ,
  output logic [DATA_W-1:0] dataQ
);
  nvdStrobes_t stb;
  logic busy, wrenQ, freeQ, finalAddr;

  nvdCtrl #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlSet(ctrlSet), .ctrlBit(ctrlBit),
    .finalAddr(finalAddr), .stb(stb), .busy(busy), .wrenQ(wrenQ), .freeQ(freeQ)
  );

  nvdPath #(.DEPTH(DEPTH), .ROW_LEN(ROW_LEN), .LATCHES(LATCHES), .DATA_W(DATA_W),
            .CELL_W(CELL_W), .REG_AW(REG_AW)) i_path (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .busy(busy), .stb(stb), .finalAddr(finalAddr), .dataQ(dataQ)
  );

  assign stall = busy;
  assign ctrlQ = {freeQ, wrenQ, busy, 1'b0};
endmodule

// File: tb/test_nvDataCtrl.sv
module test_nvDataCtrl;
  localparam int ERASE_CYC = 20;
  localparam int WRITE_CYC = 12;

  logic clk = 1'b0, rstN = 1'b0, ctrlSet = 1'b0, regWr = 1'b0, regSel = 1'b0;
  logic [2:0] ctrlBit = '0;
  logic [7:0] regWdata = '0;
  logic stall;
  logic [3:0] ctrlQ;
  logic [7:0] dataQ;
  int nChk = 0, nBad = 0;
  logic [7:0] model [64];

  always #5 clk = ~clk;

  nvDataCtrl #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) i_nvDataCtrl (
    .clk(clk), .rstN(rstN), .ctrlSet(ctrlSet), .ctrlBit(ctrlBit), .regWr(regWr),
    .regSel(regSel), .regWdata(regWdata), .stall(stall), .ctrlQ(ctrlQ), .dataQ(dataQ)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bitSet(input int idx);
    ctrlSet = 1'b1; ctrlBit = 3'(idx);
    @(negedge clk);
    ctrlSet = 1'b0;
  endtask

  task automatic setReg(input bit sel, input int val);
    regWr = 1'b1; regSel = sel; regWdata = 8'(val);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readCheck(input string req, input int a);
    setReg(1'b0, a);
    bitSet(0);
    check(req, dataQ, model[a]);
  endtask

  task automatic waitStall(output int n);
    n = 0;
    while (stall) begin
      check("R9 busy readback", ctrlQ[1], 1);
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int pat(input int a, input int k);
    return (a * k + 11 * k + 3) & 8'hFF;
  endfunction

  task automatic writeGroup(input int g, input int k);
    int n;
    for (int i = 0; i < 4; i++) begin
      setReg(1'b0, g * 4 + i);
      setReg(1'b1, pat(g * 4 + i, k));
      bitSet(2);
      bitSet(1);
      if (i < 3) check("R4 no stall on latch load", stall, 0);
    end
    for (int i = 0; i < 4; i++) model[g * 4 + i] &= 8'(pat(g * 4 + i, k));
    waitStall(n);
    check("R5 program stall length", n, WRITE_CYC);
    check("R9 ctrl idle after program", ctrlQ, 0);
  endtask

  task automatic eraseRow(input int a, input bit timed);
    int n;
    setReg(1'b0, a);
    bitSet(3);
    bitSet(2);
    bitSet(1);
    for (int j = 0; j < 8; j++) model[(a & 8'h38) + j] = 8'hFF;
    if (timed) begin
      waitStall(n);
      check("R3 erase stall length", n, ERASE_CYC);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2000000;
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int n;
    for (int a = 0; a < 64; a++) model[a] = 8'hFF;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 stall", stall, 0);
    check("R1 ctrlQ", ctrlQ, 0);
    check("R1 dataQ", dataQ, 0);
    for (int a = 0; a < 64; a++) readCheck("R1 erased cell", a);

    // R2 hold and data-register write
    readCheck("R2 read", 5);
    idle(3);
    check("R2 hold", dataQ, 8'hFF);
    setReg(1'b1, 8'h5A);
    check("R2 data write", dataQ, 8'h5A);

    // R5 program every group with a position-dependent pattern
    for (int g = 0; g < 16; g++) writeGroup(g, 37);
    for (int a = 0; a < 64; a++) readCheck("R5 programmed cell", a);

    // R11 reprogram group 2 without erase
    writeGroup(2, 91);
    for (int a = 8; a < 12; a++) readCheck("R11 AND result", a);

    // R3 erase row 1, full sweep
    eraseRow(8 + 3, 1'b1);
    check("R9 ctrl idle after erase", ctrlQ, 0);
    for (int a = 0; a < 64; a++) readCheck("R3 after erase", a);

    // R6 erase-select expires
    setReg(1'b0, 8'h10);
    bitSet(3);
    check("R6 erase-select set", ctrlQ[3], 1);
    idle(1);
    check("R6 erase-select expired", ctrlQ[3], 0);
    bitSet(2);
    bitSet(1);
    check("R6 no erase stall", stall, 0);
    for (int a = 16; a < 24; a++) readCheck("R6 row intact", a);

    // R7 write-enable expires
    setReg(1'b0, 8'h23);
    setReg(1'b1, 8'h00);
    bitSet(2);
    idle(1);
    check("R7 enable expired", ctrlQ[2], 0);
    bitSet(1);
    check("R7 no stall", stall, 0);
    readCheck("R7 cell intact", 35);

    // R8 strobe without enable
    setReg(1'b0, 8'h23);
    setReg(1'b1, 8'h00);
    bitSet(1);
    check("R8 no stall", stall, 0);
    check("R8 ctrl idle", ctrlQ, 0);
    readCheck("R8 cell intact", 35);

    // R12 low bits 11 with upper bits set
    setReg(1'b0, 8'h63);
    setReg(1'b1, 8'h00);
    bitSet(2);
    bitSet(1);
    check("R12 no stall", stall, 0);
    readCheck("R12 cell intact", 35);

    // R10 traffic during an erase stall
    setReg(1'b1, 8'h3C);
    eraseRow(32, 1'b0);
    setReg(1'b1, 8'h77);
    setReg(1'b0, 5);
    bitSet(3);
    check("R10 data ignored", dataQ, 8'h3C);
    waitStall(n);
    check("R10 erase-select ignored", ctrlQ, 0);
    bitSet(0);
    check("R10 address kept", dataQ, 8'hFF);

    // group 8 again after the erase, clearing the stray latch loads
    writeGroup(8, 53);
    for (int a = 0; a < 64; a++) readCheck("R5 final sweep", a);
    report();
  end
endmodule